// File: doc/BRIEF.md
# Clock Supervision Window Monitor

This block checks a monitored clock against a trusted reference clock and reports frequency faults or loss of the clock. A divider in the monitored domain produces an event once every programmed number of monitored cycles. Each event is carried into the reference domain as a level toggle. A counter there measures the number of reference cycles between successive events and compares that gap with a programmable window. An event that comes too early shows a fast clock. An event that comes too late, or never comes, shows a slow or stopped clock.

After enable, a programmable startup delay runs in reference cycles before checking starts. This gives the monitored clock time to settle. A fault latches a sticky error flag. Three separate enables decide whether the fault also raises a request to switch to a backup internal oscillator, a one-cycle hardware trigger and a held interrupt. The trigger and the interrupt are only produced when the switch request is enabled. All configuration values are programmed as the wanted count minus one.

Top module: `clk_window_monitor`

## Requirements
- R1: While `ref_rst` is high, and on the reference edge after `enable` is sampled low, `fault`, `switch_req`, `trig_pulse` and `irq` are all 0.
- R2: The monitored divider produces one event every `period_m1`+1 monitored-clock rising edges, counted from the release of `mon_rst`.
- R3: Window checking starts on the reference edge `startup_m1`+2 edges after the first edge on which `enable` is sampled high. Events before that point are ignored.
- R4: Let d be the number of reference edges from one accepted event to the next. If d <= `lower_m1`, the monitor flags a fault. If d = `lower_m1`+1, the event is accepted.
- R5: If no event has arrived by d = `upper_m1`+1, the monitor flags a fault on that edge. This also covers a monitored clock that has stopped. An event that arrives exactly at d = `upper_m1`+1 is accepted.
- R6: The first event after checking starts is not tested against the lower limit, because the gap before it is only partial. The upper limit still applies to it.
- R7: A monitored-domain event takes effect on the third reference rising edge after the monitored edge that produced it. Two of those edges are synchronizer stages and one is edge detection.
- R8: `fault` is sticky. While it is set, events have no effect. A one-cycle `err_clear` pulse lowers `fault`, `switch_req` and `irq` on the next edge, and the startup delay then begins again.
- R9: When a fault is flagged, `switch_req` is set to `switch_en`. `trig_pulse` is high for exactly one cycle if `switch_en` and `trig_en` are both set. `irq` is set and held if `switch_en` and `irq_en` are both set.
- R10: If `lower_m1` >= `upper_m1`, the monitor flags a fault on the first edge of checking.
- R11: `err_clear` has no effect while no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| mon_clk | input | 1 | Clock under supervision |
| mon_rst | input | 1 | Synchronous active-high reset, monitored domain |
| enable | input | 1 | Starts supervision; low clears all state |
| err_clear | input | 1 | Clears a latched fault |
| startup_m1 | input | 16 | Startup delay minus one, reference cycles |
| period_m1 | input | 16 | Event period minus one, monitored cycles |
| lower_m1 | input | 16 | Lower gap limit minus one, reference cycles |
| upper_m1 | input | 16 | Upper gap limit minus one, reference cycles |
| switch_en | input | 1 | Enables the backup-oscillator switch request |
| trig_en | input | 1 | Enables the trigger pulse on a switch |
| irq_en | input | 1 | Enables the interrupt on a switch |
| fault | output | 1 | Sticky supervision error |
| switch_req | output | 1 | Request to switch to backup oscillator |
| trig_pulse | output | 1 | One-cycle hardware trigger |
| irq | output | 1 | Interrupt level |

## Verification
On every reference cycle the assertions check the shape of the fault response: the trigger lasts one cycle and only appears when a fault begins, the interrupt and the switch request never appear without a fault, a latched fault stays set until it is cleared or the block is disabled, and disabling clears everything. Only the bench scenarios can show the exact cycle on which a fault is flagged. That cycle depends on the toggle crossing latency, the startup count, the first-gap exemption and the boundary gaps at each limit, so the bench checks it with its own event queue model, including the case where the monitored clock stops.

// File: rtl/clk_window_monitor_pkg.sv
`timescale 1ns/1ps
package clk_window_monitor_pkg;
  localparam int unsigned CFG_W = 16;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_RUN,
    ST_FAULT
  } mon_state_e;
endpackage

// File: rtl/mon_event_gen.sv
`timescale 1ns/1ps
module mon_event_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] period_m1,
  output logic         tgl
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (cnt == period_m1) begin
      cnt <= '0;
      tgl <= ~tgl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/toggle_sync.sv
`timescale 1ns/1ps
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_async,
  output logic evt
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= tgl_async;
  end

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign evt = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/window_fsm.sv
`timescale 1ns/1ps
module window_fsm
  import clk_window_monitor_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         err_clear,
  input  logic         evt,
  input  logic [W-1:0] startup_m1,
  input  logic [W-1:0] lower_m1,
  input  logic [W-1:0] upper_m1,
  output logic         fault_now,
  output logic         clr_now
);
  mon_state_e   state;
  logic [W-1:0] cnt;
  logic         first;

  always_comb begin
    fault_now = 1'b0;
    if (state == ST_RUN) begin
      if (lower_m1 >= upper_m1) fault_now = 1'b1;
      else if (evt)             fault_now = !first && (cnt < lower_m1);
      else                      fault_now = (cnt == upper_m1);
    end
    clr_now = (state == ST_FAULT) && err_clear;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state <= ST_IDLE;
      cnt   <= '0;
      first <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: begin
          if (cnt == startup_m1) begin
            state <= ST_RUN;
            cnt   <= '0;
            first <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (fault_now) begin
            state <= ST_FAULT;
          end else if (evt) begin
            cnt   <= '0;
            first <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (clr_now) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fault_response.sv
`timescale 1ns/1ps
module fault_response (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic fault_now,
  input  logic clr_now,
  input  logic switch_en,
  input  logic trig_en,
  input  logic irq_en,
  output logic fault,
  output logic switch_req,
  output logic trig_pulse,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fault      <= 1'b0;
      switch_req <= 1'b0;
      trig_pulse <= 1'b0;
      irq        <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      if (fault_now) begin
        fault      <= 1'b1;
        switch_req <= switch_en;
        trig_pulse <= switch_en && trig_en;
        irq        <= switch_en && irq_en;
      end else if (clr_now) begin
        fault      <= 1'b0;
        switch_req <= 1'b0;
        irq        <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_window_monitor.sv
`timescale 1ns/1ps
module clk_window_monitor #(
  parameter int unsigned W           = clk_window_monitor_pkg::CFG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         ref_clk,
  input  logic         ref_rst,
  input  logic         mon_clk,
  input  logic         mon_rst,
  input  logic         enable,
  input  logic         err_clear,
  input  logic [W-1:0] startup_m1,
  input  logic [W-1:0] period_m1,
  input  logic [W-1:0] lower_m1,
  input  logic [W-1:0] upper_m1,
  input  logic         switch_en,
  input  logic         trig_en,
  input  logic         irq_en,
  output logic         fault,
  output logic         switch_req,
  output logic         trig_pulse,
  output logic         irq
);
  logic mon_tgl;
  logic evt;
  logic fault_now;
  logic clr_now;

  mon_event_gen #(.W(W)) u_gen (
    .clk       (mon_clk),
    .rst       (mon_rst),
    .period_m1 (period_m1),
    .tgl       (mon_tgl)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (ref_clk),
    .rst       (ref_rst),
    .tgl_async (mon_tgl),
    .evt       (evt)
  );

  window_fsm #(.W(W)) u_fsm (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .enable     (enable),
    .err_clear  (err_clear),
    .evt        (evt),
    .startup_m1 (startup_m1),
    .lower_m1   (lower_m1),
    .upper_m1   (upper_m1),
    .fault_now  (fault_now),
    .clr_now    (clr_now)
  );

  fault_response u_resp (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .enable     (enable),
    .fault_now  (fault_now),
    .clr_now    (clr_now),
    .switch_en  (switch_en),
    .trig_en    (trig_en),
    .irq_en     (irq_en),
    .fault      (fault),
    .switch_req (switch_req),
    .trig_pulse (trig_pulse),
    .irq        (irq)
  );
endmodule

// File: rtl/clk_window_monitor_chk.sv
`timescale 1ns/1ps
module clk_window_monitor_chk (
  input logic ref_clk,
  input logic ref_rst,
  input logic enable,
  input logic err_clear,
  input logic switch_en,
  input logic fault,
  input logic switch_req,
  input logic trig_pulse,
  input logic irq
);
  assert_trig_one_cycle_R9: assert property (@(posedge ref_clk) disable iff (ref_rst)
    trig_pulse |=> !trig_pulse);

  assert_trig_on_fault_rise_R9: assert property (@(posedge ref_clk) disable iff (ref_rst)
    trig_pulse |-> $rose(fault));

  assert_switch_follows_enable_R9: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(fault) |-> (switch_req == $past(switch_en)));

  assert_irq_needs_fault_R9: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (irq || switch_req) |-> fault);

  assert_disable_clears_R1: assert property (@(posedge ref_clk) disable iff (ref_rst)
    !enable |=> (!fault && !switch_req && !irq && !trig_pulse));

  assert_fault_sticky_R8: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (fault && enable && !err_clear) |=> fault);
endmodule

bind clk_window_monitor clk_window_monitor_chk i_chk (
  .ref_clk    (ref_clk),
  .ref_rst    (ref_rst),
  .enable     (enable),
  .err_clear  (err_clear),
  .switch_en  (switch_en),
  .fault      (fault),
  .switch_req (switch_req),
  .trig_pulse (trig_pulse),
  .irq        (irq)
);

// File: tb/test_clk_window_monitor.sv
`timescale 1ns/1ps
module test_clk_window_monitor;
  logic        ref_clk = 1'b0;
  logic        mon_clk = 1'b0;
  logic        ref_rst = 1'b1;
  logic        mon_rst = 1'b1;
  logic        enable = 1'b0;
  logic        err_clear = 1'b0;
  logic [15:0] startup_m1 = 16'd0;
  logic [15:0] period_m1 = 16'd0;
  logic [15:0] lower_m1 = 16'd0;
  logic [15:0] upper_m1 = 16'd0;
  logic        switch_en = 1'b0;
  logic        trig_en = 1'b0;
  logic        irq_en = 1'b0;
  logic        fault, switch_req, trig_pulse, irq;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  real   mon_half = 1.5;
  bit    mon_run = 1'b1;

  // Reference model state
  int q_pend[$];
  int mc = 0;
  int m_state = 0;  // 0 idle, 1 startup, 2 checking, 3 faulted
  int m_cnt = 0;
  bit m_first = 0;
  bit m_fault = 0, m_sw = 0, m_trig = 0, m_irq = 0;
  bit started = 0;

  clk_window_monitor i_clk_window_monitor (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .mon_clk(mon_clk), .mon_rst(mon_rst),
    .enable(enable), .err_clear(err_clear),
    .startup_m1(startup_m1), .period_m1(period_m1),
    .lower_m1(lower_m1), .upper_m1(upper_m1),
    .switch_en(switch_en), .trig_en(trig_en), .irq_en(irq_en),
    .fault(fault), .switch_req(switch_req), .trig_pulse(trig_pulse), .irq(irq)
  );

  // 250 MHz reference clock; rising edges fall on whole nanoseconds.
  initial forever #2 ref_clk = ~ref_clk;

  // Monitored clock; edges fall on x.x5 ns, so they never coincide with reference edges.
  initial begin
    #0.05;
    forever begin
      #(mon_half);
      if (mon_run) mon_clk = ~mon_clk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Monitored-domain model: one event per period_m1+1 edges (R2), acted on 3 reference edges later (R7).
  always @(posedge mon_clk) begin
    if (mon_rst) mc = 0;
    else if (mc == int'(period_m1)) begin
      mc = 0;
      q_pend.push_back(3);
    end else mc++;
  end

  // Reference-domain behavioural model.
  always @(posedge ref_clk) begin
    bit ev;
    bit f_now;
    ev = 0;
    foreach (q_pend[i]) q_pend[i]--;
    while (q_pend.size() > 0 && q_pend[0] <= 0) begin
      void'(q_pend.pop_front());
      ev = 1;
    end
    m_trig = 0;
    if (ref_rst || !enable) begin
      m_state = 0; m_cnt = 0; m_first = 0;
      m_fault = 0; m_sw = 0; m_irq = 0;
      if (ref_rst) q_pend.delete();
    end else begin
      f_now = 0;
      case (m_state)
        0: begin m_state = 1; m_cnt = 0; end
        1: begin
          if (m_cnt == int'(startup_m1)) begin m_state = 2; m_cnt = 0; m_first = 1; end
          else m_cnt++;
        end
        2: begin
          if (lower_m1 >= upper_m1) f_now = 1;
          else if (ev) begin
            if (!m_first && m_cnt < int'(lower_m1)) f_now = 1;
            else begin m_cnt = 0; m_first = 0; end
          end else if (m_cnt == int'(upper_m1)) f_now = 1;
          else m_cnt++;
        end
        default: begin
          if (err_clear) begin
            m_state = 1; m_cnt = 0;
            m_fault = 0; m_sw = 0; m_irq = 0;
          end
        end
      endcase
      if (f_now) begin
        m_state = 3; m_fault = 1; m_sw = switch_en;
        m_trig = switch_en && trig_en; m_irq = switch_en && irq_en;
      end
    end
    started = 1;
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge ref_clk) begin
    if (started) begin
      check(fault == m_fault, cur_req, "fault vs model", int'(fault), int'(m_fault));
      check(switch_req == m_sw, cur_req, "switch_req vs model", int'(switch_req), int'(m_sw));
      check(trig_pulse == m_trig, cur_req, "trig_pulse vs model", int'(trig_pulse), int'(m_trig));
      check(irq == m_irq, cur_req, "irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic setup(input int s, input int p, input int lo, input int up,
                       input bit sw, input bit tr, input bit ir, input real h);
    @(negedge ref_clk);
    enable = 0; ref_rst = 1; mon_rst = 1; mon_run = 1; mon_half = h;
    startup_m1 = 16'(s); period_m1 = 16'(p); lower_m1 = 16'(lo); upper_m1 = 16'(up);
    switch_en = sw; trig_en = tr; irq_en = ir;
    repeat (6) @(negedge ref_clk);
    check(fault == 0 && switch_req == 0 && trig_pulse == 0 && irq == 0,
          "R1", "outputs in reset", int'({fault, switch_req, trig_pulse, irq}), 0);
    ref_rst = 0; mon_rst = 0; enable = 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  initial begin
    int trig_seen;
    // Nominal: 8 monitored cycles of 3 ns = 6 reference cycles per gap.
    cur_req = "R2";
    setup(20, 7, 3, 9, 1, 1, 1, 1.5);
    wait_cyc(300);
    check(fault == 0, "R2", "nominal clock no fault", int'(fault), 0);

    // R11: clear with no fault latched has no effect.
    cur_req = "R11";
    err_clear = 1; wait_cyc(1); err_clear = 0;
    check(fault == 0, "R11", "clear without fault", int'(fault), 0);
    wait_cyc(60);
    check(fault == 0, "R11", "still no fault after clear", int'(fault), 0);

    // R4/R6: lower limit 5 accepts gap 6; first partial gap exempt.
    cur_req = "R4";
    setup(20, 7, 5, 9, 0, 0, 0, 1.5);
    wait_cyc(200);
    check(fault == 0, "R4", "gap of lower_m1+1 accepted", int'(fault), 0);
    check(fault == 0, "R6", "first partial gap not lower-checked", int'(fault), 0);

    // R4: lower limit 6 rejects gap 6; R9 with all responses enabled.
    cur_req = "R9";
    setup(20, 7, 6, 9, 1, 1, 1, 1.5);
    trig_seen = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge ref_clk);
      if (trig_pulse) trig_seen++;
    end
    check(fault == 1, "R4", "gap equal lower_m1+0 flags fault", int'(fault), 1);
    check(trig_seen == 1, "R9", "trigger pulses once", trig_seen, 1);
    check(switch_req == 1 && irq == 1, "R9", "switch and irq set",
          int'({switch_req, irq}), 3);

    // R8: sticky fault, then clear restarts startup.
    cur_req = "R8";
    wait_cyc(50);
    check(fault == 1, "R8", "fault sticky", int'(fault), 1);
    err_clear = 1; wait_cyc(1); err_clear = 0;
    check(fault == 0 && irq == 0 && switch_req == 0, "R8", "clear lowers outputs",
          int'({fault, switch_req, irq}), 0);
    wait_cyc(15);
    check(fault == 0, "R8", "no fault during restarted startup", int'(fault), 0);
    wait_cyc(100);
    check(fault == 1, "R8", "fault returns after restart", int'(fault), 1);

    // R1: disable clears all outputs on the next edge.
    cur_req = "R1";
    enable = 0; wait_cyc(1);
    check(fault == 0 && switch_req == 0 && irq == 0, "R1", "disable clears",
          int'({fault, switch_req, irq}), 0);
    wait_cyc(5);

    // R9: switch disabled means no trigger and no irq.
    cur_req = "R9";
    setup(20, 7, 6, 9, 0, 1, 1, 1.5);
    trig_seen = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge ref_clk);
      if (trig_pulse) trig_seen++;
    end
    check(fault == 1 && switch_req == 0 && irq == 0 && trig_seen == 0, "R9",
          "responses gated by switch_en", int'({fault, switch_req, irq}), 4);

    // R5: upper limit 5 accepts gap 6, upper limit 4 rejects it.
    cur_req = "R5";
    setup(20, 7, 2, 5, 0, 0, 0, 1.5);
    wait_cyc(200);
    check(fault == 0, "R5", "gap of upper_m1+1 accepted", int'(fault), 0);
    setup(20, 7, 2, 4, 0, 0, 0, 1.5);
    wait_cyc(200);
    check(fault == 1, "R5", "gap beyond upper_m1+1 flags fault", int'(fault), 1);

    // R5: stopped monitored clock.
    setup(20, 7, 3, 9, 0, 0, 0, 1.5);
    wait_cyc(150);
    check(fault == 0, "R5", "running before stop", int'(fault), 0);
    mon_run = 0;
    wait_cyc(30);
    check(fault == 1, "R5", "stopped clock detected", int'(fault), 1);

    // R3/R10: illegal limit ordering faults exactly when checking begins.
    cur_req = "R10";
    setup(9, 7, 5, 5, 1, 0, 0, 1.5);
    wait_cyc(11);
    check(fault == 0, "R3", "no check during startup", int'(fault), 0);
    wait_cyc(1);
    check(fault == 1, "R10", "lower>=upper faults on first check edge", int'(fault), 1);

    // R7: asynchronous ratio, gaps of 6 or 7 reference cycles.
    cur_req = "R7";
    setup(25, 9, 3, 9, 1, 1, 1, 1.3);
    wait_cyc(600);
    check(fault == 0, "R7", "non-integer ratio stays in window", int'(fault), 0);

    wait_cyc(4);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule